// File: doc/BRIEF.md
# Strap-Sampling Boot Sequencer

This block controls the start-up of a switch core around its fundamental reset. While the active-low reset is low, the core stays in reset and all sampled state is cleared. The reset is synchronized on release. On the first clock edge after that, the block captures its strap inputs: a 3-bit boot mode, four slave-address pins, four memory-address pins, a bus-speed pin and a halt pin. These values do not change again until the next reset.

From the captured straps the block forms two 7-bit SMBus addresses. One is the address that its management slave answers to. The other is the address of the serial configuration memory. It also drives a speed select for the master bus. Depending on the mode it asks an external reader to load the configuration and waits for that reader to report completion. If the halt pin was high it then keeps the core in reset until software clears a pending-halt flag with a one-cycle write-one-to-clear pulse. Only after that is the core reset released. A reserved mode code stops the sequence in an error state that only a new reset leaves.

Top module: `boot_strap_seq`

## Requirements
- R1: Straps are captured on the third rising clock edge after `por_n` goes high. That is the first edge after a two-stage release synchronizer. `boot_status` reads 0 (reset) before that edge and 1 (sample) after it.
- R2: A low level on `por_n` immediately forces `core_rst_n` low and `boot_status` to 0, without waiting for a clock edge.
- R3: `slv_addr[6:0]` holds address bits 7..1. The value is {1, 1, strap_slv[3], 0, strap_slv[2], strap_slv[1], strap_slv[0]}.
- R4: `mst_addr[6:0]` holds address bits 7..1. The value is {1, 0, 1, strap_mst[3], strap_mst[2], strap_mst[1], strap_mst[0]}.
- R5: After capture, changes on any strap input have no effect on the addresses, the speed select or the sequence until `por_n` is asserted again.
- R6: With mode 0 and no halt, the state after sample is run, shown as `boot_status` 4. `core_rst_n` is high only while `boot_status` is 4, and run is kept until reset.
- R7: With mode 1 the state after sample is load, shown as `boot_status` 2. `load_req` is high exactly while in load. A high `load_done` moves the sequencer on at the next edge.
- R8: Modes 2 to 7 lead from sample to an error state, shown as `boot_status` 7. The core stays in reset, `load_req` stays low, and the state is kept whatever `load_done` and `halt_clr` do.
- R9: A high halt strap sets `halt_pending` at capture. When the load (if any) is done the sequencer waits in halt, shown as `boot_status` 3. A `halt_clr` pulse clears `halt_pending` at the next edge, and the edge after that enters run.
- R10: `bus_slow` equals the captured speed strap: 1 selects 100 kHz and 0 selects 400 kHz.
- R11: `load_done` outside the load state has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Clock |
| por_n | input | 1 | Fundamental reset, active low, asynchronous assertion |
| strap_mode | input | 3 | Boot mode strap |
| strap_slv | input | 4 | Slave address straps for bits 5,3,2,1 |
| strap_mst | input | 4 | Memory address straps for bits 4..1 |
| strap_slow | input | 1 | Master bus slow-speed strap |
| strap_halt | input | 1 | Halt-after-reset strap |
| halt_clr | input | 1 | Write-one-to-clear pulse for the halt flag |
| load_done | input | 1 | Configuration load finished |
| core_rst_n | output | 1 | Core reset, active low |
| slv_addr | output | 7 | Slave SMBus address bits 7..1 |
| mst_addr | output | 7 | Configuration memory address bits 7..1 |
| bus_slow | output | 1 | Master bus speed select |
| load_req | output | 1 | Request to load the configuration |
| halt_pending | output | 1 | Halt flag |
| boot_status | output | 3 | Sequence state code |

## Verification
The bench runs an independent cycle model against the design. It targets the exact edge on which the straps are captured: a design that sampled one edge early or late would report the wrong status and could latch straps that were still moving. It changes the straps after capture and pulses `load_done` outside the load state. A design that resampled the straps or did not qualify `load_done` would change its addresses or skip ahead. It also drives a reserved mode while pulsing both handshake inputs, and asserts reset in the middle of a cycle. An error state that leaks into run, or a reset that waits for a clock edge, would be reported there.

// File: rtl/boot_strap_seq.sv
module boot_strap_seq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       sys_clk,
  input  logic       por_n,
  input  logic [2:0] strap_mode,
  input  logic [3:0] strap_slv,
  input  logic [3:0] strap_mst,
  input  logic       strap_slow,
  input  logic       strap_halt,
  input  logic       halt_clr,
  input  logic       load_done,
  output logic       core_rst_n,
  output logic [6:0] slv_addr,
  output logic [6:0] mst_addr,
  output logic       bus_slow,
  output logic       load_req,
  output logic       halt_pending,
  output logic [2:0] boot_status
);

  typedef enum logic [2:0] {
    ST_RESET  = 3'd0,
    ST_SAMPLE = 3'd1,
    ST_LOAD   = 3'd2,
    ST_HALT   = 3'd3,
    ST_RUN    = 3'd4,
    ST_ERR    = 3'd7
  } state_t;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_s;

  always_ff @(posedge sys_clk or negedge por_n)
    if (!por_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};

  assign rst_s = sync_q[SYNC_STAGES-1];

  state_t     state, state_nx;
  logic [2:0] mode_q;
  logic [3:0] slv_q, mst_q;
  logic       slow_q, halt_q;

  always_ff @(posedge sys_clk or negedge rst_s)
    if (!rst_s) begin
      mode_q <= '0;
      slv_q  <= '0;
      mst_q  <= '0;
      slow_q <= 1'b0;
    end else if (state == ST_RESET) begin
      mode_q <= strap_mode;
      slv_q  <= strap_slv;
      mst_q  <= strap_mst;
      slow_q <= strap_slow;
    end

  always_ff @(posedge sys_clk or negedge rst_s)
    if (!rst_s)                  halt_q <= 1'b0;
    else if (state == ST_RESET)  halt_q <= strap_halt;
    else if (halt_clr)           halt_q <= 1'b0;

  always_comb begin
    state_nx = state;
    case (state)
      ST_RESET:  state_nx = ST_SAMPLE;
      ST_SAMPLE: if (mode_q > 3'd1)       state_nx = ST_ERR;
                 else if (mode_q == 3'd1) state_nx = ST_LOAD;
                 else if (halt_q)         state_nx = ST_HALT;
                 else                     state_nx = ST_RUN;
      ST_LOAD:   if (load_done)           state_nx = halt_q ? ST_HALT : ST_RUN;
      ST_HALT:   if (!halt_q)             state_nx = ST_RUN;
      default:   state_nx = state;
    endcase
  end

  always_ff @(posedge sys_clk or negedge rst_s)
    if (!rst_s) state <= ST_RESET;
    else        state <= state_nx;

  assign core_rst_n   = (state == ST_RUN);
  assign load_req     = (state == ST_LOAD);
  assign halt_pending = halt_q;
  assign bus_slow     = slow_q;
  assign boot_status  = state;
  assign slv_addr     = {2'b11, slv_q[3], 1'b0, slv_q[2:0]};
  assign mst_addr     = {3'b101, mst_q};

  AST_STRAP_HOLD: assert property (@(posedge sys_clk) disable iff (!rst_s)
    (state != ST_RESET && $past(state) != ST_RESET) |-> ($stable(slv_addr) && $stable(mst_addr) && $stable(bus_slow))); // R5
  AST_ERR_STICKY: assert property (@(posedge sys_clk) disable iff (!rst_s)
    (state == ST_ERR) |=> (state == ST_ERR && !core_rst_n)); // R8
  AST_LOAD_WAIT: assert property (@(posedge sys_clk) disable iff (!rst_s)
    (state == ST_LOAD && !load_done) |=> (state == ST_LOAD)); // R7
  AST_HALT_EXIT: assert property (@(posedge sys_clk) disable iff (!rst_s)
    (state == ST_HALT && !halt_q) |=> (state == ST_RUN)); // R9
  AST_RUN_KEEP: assert property (@(posedge sys_clk) disable iff (!rst_s)
    (state == ST_RUN) |=> (state == ST_RUN)); // R6

endmodule

// File: tb/boot_strap_seq_test.sv
`timescale 1ns/1ps
module boot_strap_seq_test;
  logic       sys_clk = 1'b0;
  logic       por_n = 1'b0;
  logic [2:0] strap_mode = '0;
  logic [3:0] strap_slv = '0, strap_mst = '0;
  logic       strap_slow = 1'b0, strap_halt = 1'b0, halt_clr = 1'b0, load_done = 1'b0;
  logic       core_rst_n, bus_slow, load_req, halt_pending;
  logic [6:0] slv_addr, mst_addr;
  logic [2:0] boot_status;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 sys_clk = ~sys_clk;

  boot_strap_seq uut (.*);

  int rel, st;
  logic [3:0] m_slv, m_mst;
  logic m_slow, m_halt;

  always @(posedge sys_clk or negedge por_n) begin
    if (!por_n) begin
      rel = 0; st = 0; m_slv = 0; m_mst = 0; m_slow = 0; m_halt = 0;
    end else if (rel < 2) rel = rel + 1;
    else begin
      int ns;
      ns = st;
      if (st == 0) begin
        m_slv = strap_slv; m_mst = strap_mst; m_slow = strap_slow; m_halt = strap_halt; ns = 1;
      end else begin
        if (st == 1) ns = (strap_mode_cap > 1) ? 7 : (strap_mode_cap == 1) ? 2 : (m_halt ? 3 : 4);
        else if (st == 2 && load_done) ns = m_halt ? 3 : 4;
        else if (st == 3 && !m_halt) ns = 4;
        if (halt_clr) m_halt = 0;
      end
      st = ns;
    end
  end

  int strap_mode_cap;
  always @(posedge sys_clk or negedge por_n)
    if (!por_n) strap_mode_cap <= 0;
    else if (rel == 2 && st == 0) strap_mode_cap <= strap_mode;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge sys_clk) if (!done) begin
    automatic int es = st;
    automatic int esa = {2'b11, m_slv[3], 1'b0, m_slv[2:0]};
    automatic int ema = {3'b101, m_mst};
    check(boot_status == es, "R1 status", boot_status, es);
    check(core_rst_n == (es == 4), "R6 core_rst_n", core_rst_n, es == 4);
    check(load_req == (es == 2), "R7 load_req", load_req, es == 2);
    check(halt_pending == m_halt, "R9 halt_pending", halt_pending, m_halt);
    check(slv_addr == esa, "R3 slv_addr", slv_addr, esa);
    check(mst_addr == ema, "R4 mst_addr", mst_addr, ema);
    check(bus_slow == m_slow, "R10 bus_slow", bus_slow, m_slow);
  end

  task automatic step(input int n);
    repeat (n) @(posedge sys_clk);
    #1;
  endtask

  task automatic boot(input logic [2:0] md, input logic [3:0] s, input logic [3:0] m,
                      input logic sl, input logic hl);
    @(posedge sys_clk); #1;
    por_n = 1'b0;
    strap_mode = md; strap_slv = s; strap_mst = m; strap_slow = sl; strap_halt = hl;
    step(3);
    por_n = 1'b1;
  endtask

  task automatic pulse_clr;
    halt_clr = 1'b1; step(1); halt_clr = 1'b0;
  endtask

  task automatic pulse_done;
    load_done = 1'b1; step(1); load_done = 1'b0;
  endtask

  initial begin
    #1;
    check(core_rst_n == 1'b0 && boot_status == 3'd0, "R2 reset state", boot_status, 0);
    // mode 0, no halt
    boot(3'd0, 4'b1010, 4'b0101, 1'b1, 1'b0);
    step(2);
    check(boot_status == 3'd0, "R1 before capture", boot_status, 0);
    step(1);
    check(boot_status == 3'd1, "R1 capture edge", boot_status, 1);
    step(1);
    check(boot_status == 3'd4 && core_rst_n, "R6 run after sample", boot_status, 4);
    check(slv_addr == 7'b1110010, "R3 slave address", slv_addr, 7'b1110010);
    check(mst_addr == 7'b1010101, "R4 memory address", mst_addr, 7'b1010101);
    strap_slv = 4'b0101; strap_mst = 4'b1010; strap_slow = 1'b0; strap_mode = 3'd6; strap_halt = 1'b1;
    step(4);
    check(slv_addr == 7'b1110010 && bus_slow == 1'b1, "R5 straps ignored", slv_addr, 7'b1110010);
    check(boot_status == 3'd4, "R5 sequence unaffected", boot_status, 4);
    // R2: mid-cycle assertion
    por_n = 1'b0;
    #0.5;
    check(core_rst_n == 1'b0 && boot_status == 3'd0, "R2 async reset", boot_status, 0);
    // mode 1, no halt, early load_done
    boot(3'd1, 4'b0111, 4'b1000, 1'b0, 1'b0);
    load_done = 1'b1; step(4); load_done = 1'b0;
    step(1);
    check(boot_status == 3'd2 && load_req, "R11 early done ignored", boot_status, 2);
    step(5);
    check(boot_status == 3'd2, "R7 waits in load", boot_status, 2);
    pulse_done;
    check(boot_status == 3'd4, "R7 load finished", boot_status, 4);
    pulse_done;
    check(boot_status == 3'd4, "R11 done in run ignored", boot_status, 4);
    // mode 1 with halt
    boot(3'd1, 4'b1111, 4'b1111, 1'b1, 1'b1);
    step(6);
    pulse_done;
    check(boot_status == 3'd3 && halt_pending, "R9 halt after load", boot_status, 3);
    step(5);
    check(boot_status == 3'd3 && !core_rst_n, "R9 held", boot_status, 3);
    pulse_clr;
    check(halt_pending == 1'b0, "R9 flag cleared", halt_pending, 0);
    step(1);
    check(boot_status == 3'd4, "R9 run after clear", boot_status, 4);
    // mode 0 with halt
    boot(3'd0, 4'b0000, 4'b0000, 1'b0, 1'b1);
    step(6);
    check(boot_status == 3'd3, "R9 halt without load", boot_status, 3);
    pulse_clr; step(1);
    check(boot_status == 3'd4 && bus_slow == 1'b0, "R10 fast bus", boot_status, 4);
    // reserved mode
    boot(3'd5, 4'b1001, 4'b0110, 1'b0, 1'b1);
    step(6);
    check(boot_status == 3'd7 && !load_req, "R8 error state", boot_status, 7);
    pulse_done; pulse_clr; step(3);
    check(boot_status == 3'd7 && !core_rst_n, "R8 error sticky", boot_status, 7);
    step(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule